// File: doc/BRIEF.md
# Eight-Bit Bidirectional Parallel Port with Open-Drain Option

This block is a small general-purpose parallel port that sits on a simple memory-mapped register bus. Software chooses for each pin whether it is an input or an output, writes the levels it wants to drive, and reads back the pin state. Every pad is modelled as three separate signals: a driven value, an output enable and a sensed value. The block therefore fits in front of any tri-state or open-drain pad cell and contains no bidirectional nets.

One control bit selects the drive style for all pins together. When it is clear, output pins drive both high and low. When it is set, every output pin becomes an open-drain driver: it pulls the pad low for a zero and releases the pad to high impedance for a one, and an external pull-up supplies the high level. Sensed pin levels pass through a two-flop synchroniser before software can read them.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset the level register, the direction register and the drive-style bit are all zero. Every `pad_oe` bit is 0 and `pad_out` is 0.
- R2: A write with `bus_wen` high changes a register on the rising clock edge of that cycle, and not before. The direction register is read and written at offset 7.
- R3: With the drive-style bit at 0, each `pad_oe` bit equals its direction bit (1 = output, 0 = input).
- R4: With the drive-style bit at 0, `pad_out` equals the level register written at offset 3.
- R5: With the drive-style bit at 1, an output pin whose level bit is 0 has `pad_oe`=1 and `pad_out`=0. An output pin whose level bit is 1 has `pad_oe`=0. `pad_out` is 0 on every bit.
- R6: A pin whose direction bit is 0 always has `pad_oe`=0, whatever its level bit and whatever the drive style.
- R7: A read at offset 3 returns the synchronised pad level for input bits and the level register for output bits.
- R8: A change on `pad_in` first appears in a read after two rising clock edges. After one edge the read still shows the old value.
- R9: The drive-style control lives at offset 2, bit 0, and the other bits of that offset read 0. Offsets 0, 1, 4, 5 and 6 read 0, and writes to them change no register.
- R10: A write to the level register while a pin is an input is stored. The stored value appears on the pad once the pin is turned into an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Sensed pad levels, asynchronous |
| pad_out | output | 8 | Value presented to the pad drivers |
| pad_oe | output | 8 | Per-pin driver enable, 1 = driving |

## Verification
The bench sweeps all 256 level values under several direction masks, in both drive styles. Three kinds of design fault show up in this sweep: a design that drives a one actively in open-drain mode, one that enables input pins, and one that ties the enable to direction alone. The mixed read is swept over pin and direction patterns, so a design that returns the level register for input bits, or pad levels for output bits, is caught. The bench also samples the read one edge after a pad change, which exposes a synchroniser that is too short. It writes to unmapped offsets and to the level register while pins are inputs, which catches stray decode and a design that drops those writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned PORT_W       = 8;
    localparam int unsigned ADDR_W       = 3;
    localparam int unsigned SYNC_DEPTH   = 2;
    localparam int unsigned CTRL_ODM_BIT = 0;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(7);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DATA,
        SEL_DIR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFS_CTRL)      s = SEL_CTRL;
        else if (a == OFS_DATA) s = SEL_DATA;
        else if (a == OFS_DIR)  s = SEL_DIR;
        else                    s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = gpio_pkg::PORT_W,
    parameter int unsigned STAGES = gpio_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic              odm_q,
    output logic [W-1:0]      rdata
);

    reg_sel_e sel;
    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            odm_q  <= 1'b0;
        end else if (wen) begin
            case (sel)
                SEL_CTRL: odm_q  <= wdata[CTRL_ODM_BIT];
                SEL_DATA: data_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: rdata[CTRL_ODM_BIT] = odm_q;
            SEL_DATA: rdata = (pin_sync & ~dir_q) | (data_q & dir_q);
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int unsigned W = gpio_pkg::PORT_W
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic         odm_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        // open-drain: only a zero is driven, a one releases the pad
        assign pad_oe[i]  = dir_q[i] & (~odm_q | ~data_q[i]);
        assign pad_out[i] = data_q[i] & ~odm_q;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);

    logic [W-1:0] pin_sync;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic         odm_q;

    gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wen      (bus_wen),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .odm_q    (odm_q),
        .rdata    (bus_rdata)
    );

    gpio_pad_ctl #(.W(W)) u_pad (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .odm_q   (odm_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pin_sync,
    input logic [W-1:0]      data_q,
    input logic [W-1:0]      dir_q,
    input logic              odm_q
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    logic unmapped;
    assign unmapped = (bus_addr != OFS_CTRL) && (bus_addr != OFS_DATA) && (bus_addr != OFS_DIR);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

    // R3
    pp_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !odm_q |-> (pad_oe == dir_q));

    // R4
    pp_level_chk: assert property (@(posedge clk) disable iff (rst)
        !odm_q |-> (pad_out == data_q));

    // R5
    od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        odm_q |-> ((pad_out & pad_oe) == '0 && (pad_oe & data_q) == '0));

    // R6
    input_released_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~dir_q) == '0);

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && unmapped) |=> ($stable(dir_q) && $stable(data_q) && $stable(odm_q)));

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pin_sync  (pin_sync),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .odm_q     (odm_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    localparam time CYC = 5ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wen = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int errors = 0;

    always #(CYC/2) clk = ~clk;

    gpio_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CYC * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] masks [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        bus_rd(3'd7, rd); check("R1 dir", rd, 8'h00);
        bus_rd(3'd2, rd); check("R1 ctrl", rd, 8'h00);

        // R2 write lands on the edge, not before
        @(negedge clk);
        bus_addr = 3'd7; bus_wdata = 8'h5A; bus_wen = 1'b1;
        #1; check("R2 before edge", bus_rdata, 8'h00);
        @(negedge clk);
        bus_wen = 1'b0;
        #1; check("R2 after edge", bus_rdata, 8'h5A);

        // R3 R4 R5 R6 sweep
        for (int m = 0; m < 2; m++) begin
            bus_wr(3'd2, 8'(m));
            for (int k = 0; k < 4; k++) begin
                bus_wr(3'd7, masks[k]);
                for (int v = 0; v < 256; v++) begin
                    logic [7:0] eoe;
                    logic [7:0] eout;
                    bus_wr(3'd3, 8'(v));
                    #1;
                    if (m == 0) begin
                        eoe  = masks[k];
                        eout = 8'(v);
                        check("R3 pp enable", pad_oe, eoe);
                        check("R4 pp level", pad_out, eout);
                    end else begin
                        eoe  = masks[k] & ~8'(v);
                        eout = 8'h00;
                        check("R5 od enable", pad_oe, eoe);
                        check("R5 od level", pad_out, eout);
                    end
                    check("R6 input released", pad_oe & ~masks[k], 8'h00);
                end
            end
        end

        // R7 mixed read
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd3, 8'hC3);
        for (int k = 0; k < 4; k++) begin
            bus_wr(3'd7, masks[k]);
            for (int p = 0; p < 16; p++) begin
                logic [7:0] pin;
                pin = 8'(p * 8'h11) ^ 8'h69;
                @(negedge clk); pad_in = pin;
                @(negedge clk); @(negedge clk);
                bus_rd(3'd3, rd);
                check("R7 mixed read", rd, (pin & ~masks[k]) | (8'hC3 & masks[k]));
            end
        end

        // R8 synchroniser latency
        bus_wr(3'd7, 8'h00);
        @(negedge clk); pad_in = 8'h00;
        @(negedge clk); @(negedge clk);
        @(negedge clk); pad_in = 8'hB6;
        @(negedge clk);
        bus_rd(3'd3, rd); check("R8 one edge", rd, 8'h00);
        @(negedge clk);
        bus_rd(3'd3, rd); check("R8 two edges", rd, 8'hB6);

        // R9 control layout and unmapped offsets
        bus_wr(3'd2, 8'hFF);
        bus_rd(3'd2, rd); check("R9 ctrl bits", rd, 8'h01);
        bus_wr(3'd2, 8'hFE);
        bus_rd(3'd2, rd); check("R9 ctrl clear", rd, 8'h00);
        bus_wr(3'd7, 8'hF0);
        bus_wr(3'd3, 8'h96);
        for (int a = 0; a < 8; a++) begin
            if (a == 0 || a == 1 || a == 4 || a == 5 || a == 6) begin
                bus_wr(3'(a), 8'hFF);
                bus_rd(3'(a), rd); check("R9 unmapped read", rd, 8'h00);
                bus_rd(3'd7, rd);  check("R9 dir kept", rd, 8'hF0);
                bus_rd(3'd2, rd);  check("R9 ctrl kept", rd, 8'h00);
                #1; check("R9 level kept", pad_out, 8'h96);
            end
        end

        // R10 level written while input is kept
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd3, 8'h3D);
        #1; check("R10 inputs released", pad_oe, 8'h00);
        bus_wr(3'd7, 8'hFF);
        #1; check("R10 stored level", pad_out, 8'h3D);
        bus_rd(3'd3, rd); check("R10 readback", rd, 8'h3D);

        finish_run();
    end

endmodule